// File: doc/BRIEF.md
# Two-Plane Cursor Overlay

This block lays a 64x64 pixel, 2-bit-per-pixel cursor image over a stream of display pixels. For every pixel it is given the raster column and line counters and the underlying pixel colour. It then delivers either that pixel unchanged or one of three cursor colours, always two clock cycles later. The cursor image lives in an external 1024-byte RAM that the block only reads. The RAM holds two bit planes of 512 bytes each and is read through two synchronous read ports with one cycle of read latency.

The programmed cursor position names the bottom-right pixel of the cursor square, not its top-left. The position is captured on a frame-start pulse, so software may update the low and high position bytes at any time without tearing the cursor within a frame. The overlay is enabled by two cursor-mode bits and a large-cursor mode bit. Interlaced scanning is not handled.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `pix_out` is zero.
- R2: With the latched position (PX, PY), a pixel at (hcount, vcount) is covered only when PX-63 <= hcount <= PX and PY-63 <= vcount <= PY, using unsigned 12-bit counters with no wrap. The cursor column is hcount-(PX-63) and the cursor row is vcount-(PY-63). Pixels outside this square pass through unchanged.
- R3: For a covered pixel at column c and row r, plane 0 is read at byte address r*8 + c/8, and plane 1 is read at that address plus 512. Inside each byte, bit 7 holds the leftmost pixel, so column c uses bit 7-(c mod 8).
- R4: A covered pixel whose code {plane1 bit, plane0 bit} is 00 is transparent: `pix_out` equals `pix_in`.
- R5: Codes 01, 10 and 11 replace the pixel with `cur_col1`, `cur_col2` and `cur_col3` respectively.
- R6: The overlay acts only when `mode_bits` is nonzero and `big_mode` is 1. Otherwise every pixel passes through.
- R7: `pos_x`/`pos_y` are latched on a clock edge where `frame_start` is 1. That edge's own pixel still uses the previous position. Changes at any other time have no effect on the output.
- R8: Every pixel, covered or not, appears at `pix_out` exactly two clock edges after its inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: latch cursor position |
| hcount | input | 12 | Raster column of current pixel |
| vcount | input | 12 | Raster line of current pixel |
| pix_in | input | 24 | Underlying pixel colour |
| pos_x | input | 12 | Cursor bottom-right column |
| pos_y | input | 12 | Cursor bottom-right line |
| mode_bits | input | 2 | Cursor mode; zero disables |
| big_mode | input | 1 | 64x64 cursor mode select |
| cur_col1 | input | 24 | Cursor colour for code 01 |
| cur_col2 | input | 24 | Cursor colour for code 10 |
| cur_col3 | input | 24 | Cursor colour for code 11 |
| rd_addr_a | output | 10 | Plane 0 RAM read address |
| rd_data_a | input | 8 | Plane 0 RAM read data (one cycle after address) |
| rd_addr_b | output | 10 | Plane 1 RAM read address |
| rd_data_b | input | 8 | Plane 1 RAM read data (one cycle after address) |
| pix_out | output | 24 | Composited pixel |

## Verification
Two functions can meet in one cycle: a frame-start position capture and a covered pixel. In that cycle the pixel must still use the old position, while a pixel one cycle later uses the new one. The bench sends frame-start together with a pixel and changes `pos_x`/`pos_y` partway through frames, inside the cursor square. Its model keeps its own latched copy, updated only after that cycle's expected value has been computed, and every output is compared against that model.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int BYTE_W   = 8;
  localparam int BIT_LOG  = $clog2(BYTE_W);
  typedef logic [1:0] cur_code_t;
  localparam cur_code_t CODE_CLEAR = 2'b00;
  localparam cur_code_t CODE_COL1  = 2'b01;
  localparam cur_code_t CODE_COL2  = 2'b10;
endpackage

// File: rtl/cursor_pos_latch.sv
module cursor_pos_latch #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  output logic [CW-1:0] lat_x,
  output logic [CW-1:0] lat_y
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_x <= '0;
      lat_y <= '0;
    end else if (frame_start) begin
      lat_x <= pos_x;
      lat_y <= pos_y;
    end
  end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int CW   = 12,
  parameter int PIXW = 24,
  parameter int CUR  = 64,
  localparam int CUR_LOG = $clog2(CUR),
  localparam int PA_W    = 2 * CUR_LOG - BIT_LOG,
  localparam int AW      = PA_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       hcount,
  input  logic [CW-1:0]       vcount,
  input  logic [CW-1:0]       lat_x,
  input  logic [CW-1:0]       lat_y,
  input  logic                enable,
  input  logic [PIXW-1:0]     pix_in,
  output logic [1:0][AW-1:0]  rd_addr,
  output logic                s1_hit,
  output logic [BIT_LOG-1:0]  s1_bit,
  output logic [PIXW-1:0]     s1_pix
);
  // distance from the bottom-right corner back to the current pixel
  logic [CW:0] dx, dy;
  logic        in_x, in_y;
  logic [CUR_LOG-1:0] col, row;
  logic [PA_W-1:0]    plane_addr;

  always_comb begin
    dx   = {1'b0, lat_x} - {1'b0, hcount};
    dy   = {1'b0, lat_y} - {1'b0, vcount};
    in_x = !dx[CW] && (dx[CW-1:CUR_LOG] == '0);
    in_y = !dy[CW] && (dy[CW-1:CUR_LOG] == '0);
    col  = ~dx[CUR_LOG-1:0];
    row  = ~dy[CUR_LOG-1:0];
    plane_addr = {row, col[CUR_LOG-1:BIT_LOG]};
  end

  // one read port per bit plane; top address bit selects the plane
  for (genvar p = 0; p < 2; p++) begin : g_plane
    assign rd_addr[p] = {p[0], plane_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit <= 1'b0;
      s1_bit <= '0;
      s1_pix <= '0;
    end else begin
      s1_hit <= enable && in_x && in_y;
      s1_bit <= dx[BIT_LOG-1:0];   // 7 - (col mod 8): bit 7 is leftmost
      s1_pix <= pix_in;
    end
  end
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
#(
  parameter int PIXW = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s1_hit,
  input  logic [BIT_LOG-1:0]  s1_bit,
  input  logic [PIXW-1:0]     s1_pix,
  input  logic [BYTE_W-1:0]   plane0,
  input  logic [BYTE_W-1:0]   plane1,
  input  logic [PIXW-1:0]     cur_col1,
  input  logic [PIXW-1:0]     cur_col2,
  input  logic [PIXW-1:0]     cur_col3,
  output logic [PIXW-1:0]     pix_out
);
  cur_code_t       code;
  logic [PIXW-1:0] nxt;

  always_comb begin
    code = {plane1[s1_bit], plane0[s1_bit]};
    nxt  = s1_pix;
    if (s1_hit) begin
      unique case (code)
        CODE_CLEAR: nxt = s1_pix;
        CODE_COL1:  nxt = cur_col1;
        CODE_COL2:  nxt = cur_col2;
        default:    nxt = cur_col3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= nxt;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CW   = 12,
  parameter int PIXW = 24,
  parameter int CUR  = 64,
  localparam int CUR_LOG = $clog2(CUR),
  localparam int AW      = 2 * CUR_LOG - BIT_LOG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [CW-1:0]     hcount,
  input  logic [CW-1:0]     vcount,
  input  logic [PIXW-1:0]   pix_in,
  input  logic [CW-1:0]     pos_x,
  input  logic [CW-1:0]     pos_y,
  input  logic [1:0]        mode_bits,
  input  logic              big_mode,
  input  logic [PIXW-1:0]   cur_col1,
  input  logic [PIXW-1:0]   cur_col2,
  input  logic [PIXW-1:0]   cur_col3,
  output logic [AW-1:0]     rd_addr_a,
  input  logic [BYTE_W-1:0] rd_data_a,
  output logic [AW-1:0]     rd_addr_b,
  input  logic [BYTE_W-1:0] rd_data_b,
  output logic [PIXW-1:0]   pix_out
);
  logic [CW-1:0]        lat_x, lat_y;
  logic [1:0][AW-1:0]   rd_addr;
  logic                 s1_hit;
  logic [BIT_LOG-1:0]   s1_bit;
  logic [PIXW-1:0]      s1_pix;
  logic                 enable;

  assign enable    = (mode_bits != 2'b00) && big_mode;
  assign rd_addr_a = rd_addr[0];
  assign rd_addr_b = rd_addr[1];

  cursor_pos_latch #(.CW(CW)) u_pos (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pos_x(pos_x), .pos_y(pos_y), .lat_x(lat_x), .lat_y(lat_y)
  );

  cursor_hit #(.CW(CW), .PIXW(PIXW), .CUR(CUR)) u_hit (
    .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
    .lat_x(lat_x), .lat_y(lat_y), .enable(enable), .pix_in(pix_in),
    .rd_addr(rd_addr), .s1_hit(s1_hit), .s1_bit(s1_bit), .s1_pix(s1_pix)
  );

  cursor_mix #(.PIXW(PIXW)) u_mix (
    .clk(clk), .rst(rst), .s1_hit(s1_hit), .s1_bit(s1_bit), .s1_pix(s1_pix),
    .plane0(rd_data_a), .plane1(rd_data_b),
    .cur_col1(cur_col1), .cur_col2(cur_col2), .cur_col3(cur_col3),
    .pix_out(pix_out)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int CW   = 12,
  parameter int PIXW = 24,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_start,
  input logic [CW-1:0]   vcount,
  input logic [PIXW-1:0] pix_in,
  input logic [1:0]      mode_bits,
  input logic            big_mode,
  input logic [CW-1:0]   lat_x,
  input logic [CW-1:0]   lat_y,
  input logic [AW-1:0]   rd_addr_a,
  input logic [AW-1:0]   rd_addr_b,
  input logic [PIXW-1:0] pix_out
);
  logic [1:0] warm_cnt;
  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  // R1
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> pix_out == '0);

  // R3: planes differ only in the top address bit
  p_plane_split_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_addr_a[AW-1] && rd_addr_b[AW-1] && rd_addr_a[AW-2:0] == rd_addr_b[AW-2:0]);

  // R2 and R8: below the square's bottom edge, pixel passes through two edges later
  p_below_window_r2: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt == 2'd2 && $past(vcount, 2) > $past(lat_y, 2))
      |-> pix_out == $past(pix_in, 2));

  // R6 and R8: disabled overlay passes through with fixed latency
  p_disabled_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt == 2'd2 && ($past(mode_bits, 2) == 2'b00 || !$past(big_mode, 2)))
      |-> pix_out == $past(pix_in, 2));

  // R7
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(lat_x) && $stable(lat_y));
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .PIXW(PIXW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .vcount(vcount),
  .pix_in(pix_in), .mode_bits(mode_bits), .big_mode(big_mode),
  .lat_x(lat_x), .lat_y(lat_y), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
  .pix_out(pix_out)
);

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [11:0] hcount = '0, vcount = '0, pos_x = '0, pos_y = '0;
  logic [23:0] pix_in = '0;
  logic [1:0]  mode_bits = '0;
  logic        big_mode = 1'b0;
  logic [23:0] cur_col1 = 24'hFF0011, cur_col2 = 24'h00EE22, cur_col3 = 24'h3300DD;
  logic [9:0]  rd_addr_a, rd_addr_b;
  logic [7:0]  rd_data_a = '0, rd_data_b = '0;
  logic [23:0] pix_out;

  logic [7:0] mem [1024];

  cursor_overlay uut (.*);

  always #10 clk = ~clk;   // 50 MHz

  always_ff @(posedge clk) begin
    rd_data_a <= mem[rd_addr_a];
    rd_data_b <= mem[rd_addr_b];
  end

  int n_checks = 0, n_fail = 0;
  // bench-side wishes, applied at the next drive edge
  logic [11:0] w_px = '0, w_py = '0;
  logic [1:0]  w_mode = '0;
  logic        w_big = 1'b0;
  int lat_x = 0, lat_y = 0;
  logic [23:0] exp1, exp2;
  string tag1, tag2;
  bit v1 = 0, v2 = 0;

  task automatic check(input logic [23:0] act, input logic [23:0] expv, input string tg);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: pix_out=%h expected %h", tg, act, expv);
    end
  endtask

  function automatic logic [23:0] model(input int hx, input int vy, input logic [23:0] p,
                                        output string tg);
    int col, row, a, b;
    logic [1:0] code;
    if (w_mode == 2'b00 || !w_big) begin tg = "R6"; return p; end
    col = hx - (lat_x - 63);
    row = vy - (lat_y - 63);
    if (col < 0 || col > 63 || row < 0 || row > 63) begin tg = "R2"; return p; end
    a = row * 8 + col / 8;
    b = 7 - (col % 8);
    code = {mem[512 + a][b], mem[a][b]};
    case (code)
      2'b00: begin tg = "R4"; return p; end
      2'b01: begin tg = "R5"; return cur_col1; end
      2'b10: begin tg = "R5"; return cur_col2; end
      default: begin tg = "R5"; return cur_col3; end
    endcase
  endfunction

  // one pixel per clock: check the pixel from two cycles ago, then drive a new one
  task automatic step(input int hx, input int vy, input bit fs, input string force_tag);
    string tg;
    @(negedge clk);
    if (v2) check(pix_out, exp2, {tag2, " (R8 two-cycle latency)"});
    v2 = v1; exp2 = exp1; tag2 = tag1;
    hcount = 12'(hx); vcount = 12'(vy); frame_start = fs;
    pix_in = 24'($urandom);
    pos_x = w_px; pos_y = w_py; mode_bits = w_mode; big_mode = w_big;
    exp1 = model(int'(hcount), int'(vcount), pix_in, tg);
    tag1 = (force_tag != "") ? force_tag : tg;
    v1 = 1;
    if (fs) begin lat_x = int'(pos_x); lat_y = int'(pos_y); end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++; n_checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix_out, 24'h0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check(pix_out, 24'h0, "R1 after reset");

    // disabled overlay, pure latency
    for (int i = 0; i < 4; i++) step(i, 0, 0, "R8");

    // directed addressing: pos (100,100) -> origin at (37,37)
    mem[0] = 8'h80; mem[512] = 8'h00;         // col0,row0 -> code 01; col1 -> 00
    mem[511] = 8'h00; mem[1023] = 8'h01;      // col63,row63 -> code 10
    mem[8] = 8'h00; mem[520] = 8'h80;         // col0,row1 -> code 10
    w_px = 12'd100; w_py = 12'd100; w_mode = 2'd1; w_big = 1'b1;
    step(0, 0, 1, "");
    step(37, 37, 0, "R3 leftmost bit");
    step(38, 37, 0, "R3 transparent neighbour");
    step(100, 100, 0, "R3 plane1 last byte");
    step(37, 38, 0, "R3 row stride");
    step(36, 37, 0, "R2 left of square");
    step(101, 100, 0, "R2 right of square");
    step(37, 36, 0, "R2 above square");
    // frame-start edge with a covered pixel uses the old position
    w_px = 12'd200; w_py = 12'd200;
    step(37, 37, 1, "R7 capture edge uses old");
    step(137, 137, 0, "R7 new position");
    step(37, 37, 0, "R7 old origin now outside");
    w_big = 1'b0;
    step(137, 137, 0, "R6 big_mode off");
    w_big = 1'b1; w_mode = 2'd0;
    step(137, 137, 0, "R6 mode bits zero");

    // random frames
    for (int f = 0; f < 40; f++) begin
      case (f % 4)
        0: begin w_px = 12'($urandom % 63); w_py = 12'($urandom % 63); end
        1: begin w_px = 12'(4095 - $urandom % 8); w_py = 12'(4095 - $urandom % 8); end
        default: begin w_px = 12'($urandom); w_py = 12'($urandom); end
      endcase
      w_mode = 2'($urandom);
      w_big  = ($urandom % 5) != 0;
      step(int'(w_px), int'(w_py), 1, "");
      for (int i = 0; i < 150; i++) begin
        int hx = lat_x - 66 + int'($urandom % 70);
        int vy = lat_y - 66 + int'($urandom % 70);
        if (i == 75) begin w_px = 12'($urandom); w_py = 12'($urandom); end
        step(hx & 12'hFFF, vy & 12'hFFF, 0, (i > 75) ? "R7 mid-frame move ignored" : "");
      end
    end
    step(0, 0, 0, "");
    step(0, 0, 0, "");
    step(0, 0, 0, "");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule